// File: doc/BRIEF.md
# GPIO Port with Bit-Set Read-Modify-Write

This block is an 8-bit general-purpose I/O port. It has a direction register and an output data register, both written by a host. Each pin is driven only when its direction bit selects output. A host read returns a per-bit blend: synchronized live pin levels for input bits and latched data for output bits.

A small sequencer performs a single-bit set on the port. It reads the blended byte, forces the addressed bit to 1, and writes the whole byte back into the data register. Because the write-back covers every bit, the latch bits of input pins pick up whatever level their pins showed at sampling time. A host that later turns such a pin into an output must take this into account.

Top module: `gpio_bitset_port`

## Requirements
- R1: After reset the direction and data registers are all zeros. `pin_oe`, `pin_out`, `rd_data`, `bs_busy` and `bs_done` are all 0.
- R2: A direction bit of 1 makes the bit an output: `pin_oe` equals the direction register, and `pin_out` shows the data-register bit one edge after a host data write.
- R3: For a bit whose direction bit is 0, `pin_out` is 0 whatever the data register holds.
- R4: `rd_data` is registered and shows, for each bit, the data-register bit when its direction bit is 1 and the synchronized pin level when it is 0. A data or direction write is visible two edges after it is taken. A pin change is visible three edges after it settles, through a two-flop synchronizer and the read register.
- R5: A bit-set command is `bs_start` with a 3-bit bit number on `bs_index`. It is accepted on an edge where the sequencer is idle and commits on the third rising edge counted from that edge. After the commit, the addressed data-register bit is 1.
- R6: The committed byte is the blended read byte captured at the accepting edge, with the addressed bit forced to 1. Data-register bits of input pins take the captured pin levels. Example: data 0x80, bits 7 and 6 inputs at low and high, bits 5..0 outputs at 0, setting bit 0 leaves 0x41.
- R7: After the commit, an addressed bit configured as output drives 1 on `pin_out`, and all other output pins keep their previous levels.
- R8: `bs_busy` is 1 from the accepting edge until the commit edge. `bs_done` is 1 for exactly one cycle, the cycle just after the commit edge.
- R9: `bs_start` is ignored while `bs_busy` is 1: no second commit and no second done pulse follow.
- R10: A host data write taken on the same edge as a bit-set commit is discarded; the bit-set result is kept.
- R11: A bit-set never changes the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wdata | input | WIDTH | Write value for data or direction register |
| data_we | input | 1 | Write strobe for the data register |
| dir_we | input | 1 | Write strobe for the direction register |
| rd_data | output | WIDTH | Registered blended port read |
| bs_start | input | 1 | Bit-set command strobe |
| bs_index | input | IDX_W | Bit number to set |
| bs_busy | output | 1 | Bit-set sequence in progress |
| bs_done | output | 1 | One-cycle completion pulse |
| pin_in | input | WIDTH | Asynchronous pin levels |
| pin_out | output | WIDTH | Pin drive values (0 on input bits) |
| pin_oe | output | WIDTH | Pin output enables |

## Verification
The bench builds the block with its defaults: 8 bits and a two-stage synchronizer. With these values every bit number and every direction/data/pin combination of a byte can be reached in random trials. The three-edge pin latency and the three-edge commit also stay short enough that collisions can be timed exactly. In particular, a host write can be landed on the commit edge, and a start can be held through the busy window.

// File: rtl/gpio_bs_pkg.sv
package gpio_bs_pkg;
  typedef enum logic [1:0] {
    BS_IDLE   = 2'd0,
    BS_MODIFY = 2'd1,
    BS_WRITE  = 2'd2
  } bs_state_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_async,
  output logic [WIDTH-1:0] pin_sync
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= pin_async;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] latch,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] blended,
  output logic [WIDTH-1:0] rd_q
);
  // per-bit selection between latch (output) and pin (input)
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign blended[b] = dir[b] ? latch[b] : pin_sync[b];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= blended;
  end

  // R4: output-configured bits of the read register follow the latch
  assert_rd_output_bits_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rd_q & $past(dir)) == ($past(latch) & $past(dir))));
endmodule

// File: rtl/gpio_bitset_seq.sv
module gpio_bitset_seq
  import gpio_bs_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W-1:0] index,
  input  logic [WIDTH-1:0] blended,
  output logic             busy,
  output logic             done,
  output logic             wb_en,
  output logic [WIDTH-1:0] wb_data
);
  bs_state_e        state_q;
  logic [WIDTH-1:0] work_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BS_IDLE;
      work_q  <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        BS_IDLE: if (start) begin
          work_q  <= blended;
          idx_q   <= index;
          state_q <= BS_MODIFY;
        end
        BS_MODIFY: begin
          work_q[idx_q] <= 1'b1;
          state_q       <= BS_WRITE;
        end
        BS_WRITE: begin
          state_q <= BS_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= BS_IDLE;
      endcase
    end
  end

  assign busy    = (state_q != BS_IDLE);
  assign wb_en   = (state_q == BS_WRITE);
  assign wb_data = work_q;
  assign done    = done_q;

  // R8: an accepted start raises busy on the next cycle
  assert_start_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R8: done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: a busy sequence advances regardless of start
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == BS_MODIFY) |=> (state_q == BS_WRITE));
  // R5: the write-back byte carries the addressed bit set
  assert_bit_forced_R5: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> wb_data[idx_q]);
endmodule

// File: rtl/gpio_bitset_port.sv
module gpio_bitset_port #(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] host_wdata,
  input  logic             data_we,
  input  logic             dir_we,
  output logic [WIDTH-1:0] rd_data,
  input  logic             bs_start,
  input  logic [IDX_W-1:0] bs_index,
  output logic             bs_busy,
  output logic             bs_done,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] blended;
  logic             wb_en;
  logic [WIDTH-1:0] wb_data;

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_async(pin_in), .pin_sync(pin_sync)
  );

  gpio_read_mux #(.WIDTH(WIDTH)) u_mux (
    .clk(clk), .rst(rst), .dir(dir_q), .latch(data_q),
    .pin_sync(pin_sync), .blended(blended), .rd_q(rd_data)
  );

  gpio_bitset_seq #(.WIDTH(WIDTH)) u_seq (
    .clk(clk), .rst(rst), .start(bs_start), .index(bs_index),
    .blended(blended), .busy(bs_busy), .done(bs_done),
    .wb_en(wb_en), .wb_data(wb_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      data_q <= '0;
    end else begin
      if (dir_we) dir_q <= host_wdata;
      if (wb_en)        data_q <= wb_data;   // bit-set wins over host
      else if (data_we) data_q <= host_wdata;
    end
  end

  assign pin_oe  = dir_q;
  assign pin_out = data_q & dir_q;

  // R10: a write-back lands in the data register even under a host write
  assert_wb_wins_R10: assert property (@(posedge clk) disable iff (rst)
    wb_en |=> (data_q == $past(wb_data)));
endmodule

// File: tb/test_gpio_bitset_port.sv
module test_gpio_bitset_port;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] host_wdata = '0;
  logic data_we = 1'b0, dir_we = 1'b0;
  logic [W-1:0] rd_data;
  logic bs_start = 1'b0;
  logic [2:0] bs_index = '0;
  logic bs_busy, bs_done;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out, pin_oe;

  int n_run = 0, n_fail = 0, cycles = 0;
  logic [W-1:0] cur_dir = '0, cur_dr = '0, cur_pin = '0;

  always #5 clk = ~clk;

  gpio_bitset_port i_gpio_bitset_port (
    .clk(clk), .rst(rst), .host_wdata(host_wdata), .data_we(data_we),
    .dir_we(dir_we), .rd_data(rd_data), .bs_start(bs_start),
    .bs_index(bs_index), .bs_busy(bs_busy), .bs_done(bs_done),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [W-1:0] mix(logic [W-1:0] d, logic [W-1:0] r, logic [W-1:0] p);
    return (d & r) | (~d & p);
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic set_dir(logic [W-1:0] v);
    dir_we = 1'b1; host_wdata = v; tick(); dir_we = 1'b0; cur_dir = v;
  endtask
  task automatic set_data(logic [W-1:0] v);
    data_we = 1'b1; host_wdata = v; tick(); data_we = 1'b0; cur_dr = v;
  endtask
  task automatic set_pins(logic [W-1:0] v);
    pin_in = v; cur_pin = v; repeat (3) tick();
  endtask

  // clash: 0 plain, 1 host write on commit edge, 2 start held while busy
  task automatic bitset(logic [2:0] idx, int clash);
    logic [W-1:0] exp;
    logic [W-1:0] dir_before;
    exp = mix(cur_dir, cur_dr, cur_pin) | (W'(1) << idx);
    dir_before = cur_dir;
    bs_start = 1'b1; bs_index = idx;
    tick();                                   // accepting edge
    if (clash == 2) bs_index = idx + 3'd3; else bs_start = 1'b0;
    chk("R8 busy after accept", W'(bs_busy), W'(1));
    tick();
    if (clash == 2) bs_start = 1'b0;
    chk("R8 no early done", W'(bs_done), W'(0));
    if (clash == 1) begin data_we = 1'b1; host_wdata = ~exp; end
    tick();                                   // commit edge
    data_we = 1'b0;
    chk("R8 done after commit", W'(bs_done), W'(1));
    chk("R7 pin_out after set", pin_out, exp & cur_dir);
    if (clash == 1) chk("R10 commit beats host write", pin_out, exp & cur_dir);
    tick();
    cur_dr = exp;
    chk("R8 done one cycle", W'(bs_done), W'(0));
    chk("R8 idle again", W'(bs_busy), W'(0));
    chk("R11 direction untouched", pin_oe, dir_before);
    chk("R5 read after set", rd_data, mix(cur_dir, cur_dr, cur_pin));
    if (clash == 2) begin
      repeat (4) begin
        tick();
        chk("R9 no second done", W'(bs_done), W'(0));
      end
    end
  endtask

  task automatic readback_dr(string req);
    set_dir('1); tick();
    chk(req, rd_data, cur_dr);
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 rd_data", rd_data, '0);
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 pin_out", pin_out, '0);
    chk("R1 busy/done", {6'b0, bs_busy, bs_done}, '0);

    // R2, R3, R4 directed
    set_dir(8'h0F); set_data(8'hA5);
    chk("R2 pin_oe", pin_oe, 8'h0F);
    chk("R3 input bits undriven", pin_out, 8'h05);
    set_pins(8'h3C);
    chk("R4 blended read", rd_data, mix(8'h0F, 8'hA5, 8'h3C));
    pin_in = 8'hC3; tick(); tick();
    chk("R4 pin latency not yet", rd_data, mix(8'h0F, 8'hA5, 8'h3C));
    tick(); cur_pin = 8'hC3;
    chk("R4 pin latency three edges", rd_data, mix(8'h0F, 8'hA5, 8'hC3));

    // R6: worked example
    set_dir(8'h3F); set_data(8'h80); set_pins(8'h40);
    bitset(3'd0, 0);
    chk("R6 pins after example", pin_out, 8'h01);
    readback_dr("R6 data becomes 0x41");
    chk("R6 exact value", cur_dr, 8'h41);

    // R9: start held while busy
    set_dir(8'hF0); set_data(8'h00); set_pins(8'h0A);
    bitset(3'd6, 2);
    readback_dr("R9 only one commit");

    // R10: host write on the commit edge
    set_dir(8'hAA); set_data(8'h22); set_pins(8'h55);
    bitset(3'd3, 1);
    readback_dr("R10 data keeps bit-set result");

    // R5/R6/R7 random trials
    for (int t = 0; t < 40; t++) begin
      logic [2:0] ix;
      ix = 3'($urandom_range(0, 7));
      set_dir(8'($urandom)); set_data(8'($urandom)); set_pins(8'($urandom));
      chk("R4 random read", rd_data, mix(cur_dir, cur_dr, cur_pin));
      bitset(ix, 0);
      readback_dr("R6 random full write-back");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule